// File: doc/BRIEF.md
# DMA Channel Interrupt and Reset Register Bank

This block is the control and status register bank that sits beside a multi-channel DMA engine. Each channel reports two kinds of events: a completion pulse, and an error pulse that comes with a qualifier saying whether the fault was a bus error or a termination. The bank latches these events into sticky flags, masks the completion flags with per-channel enables, and drives one interrupt line per channel. Software reads the flags over a simple single-cycle register port and acknowledges them.

Every register can be reached at four addresses. One address overwrites the register. One ORs the written ones into it. One clears the written ones. One inverts them. Software can therefore acknowledge one channel without a read-modify-write that might lose an event arriving from another channel. The bank also holds a per-channel reset field. Writing a one there sends a reset pulse of fixed length to that channel, and the bit reads back as busy until the sequence is over.

Each channel's reset is run by its own small state machine. The states are `CR_IDLE`, `CR_PULSE` and `CR_RELEASE`:
- `CR_IDLE` moves to `CR_PULSE` on a start request.
- `CR_PULSE` stays put while its cycle count is below `RST_CYCLES-1`, and moves to `CR_RELEASE` when the count reaches that value.
- `CR_RELEASE` always returns to `CR_IDLE` on the next cycle.
- Reset forces every channel to `CR_IDLE`.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset every register reads 0, and all `irq` and `chan_rst` lines are low.
- R2: Address bits [5:4] select the register: 0 is the reset field, 1 is the completion register and 2 is the error register. Bits [3:2] select the access: 0 overwrites, 1 sets, 2 clears and 3 toggles. Bits [1:0] and [7:6] must be 0. A read at any alias of a register returns that register. Every other address reads 0 and ignores writes.
- R3: A pulse on `cmplt_evt[n]` sets bit n of the completion register. Bits n+NCH of that register are the interrupt enables, and these are software-only.
- R4: A pulse on `err_evt[n]` sets bit n of the error register. In the same cycle it loads bit n+NCH from `err_is_bus[n]`: 1 means a bus error and 0 means a termination.
- R5: An overwrite replaces the register. A set access ORs in the written ones and leaves every other bit alone. A clear access zeroes the written ones. A toggle access inverts the written ones.
- R6: If a hardware event and a software write change the same bit in the same cycle, the event's value wins.
- R7: `irq[n]` is high whenever completion bit n and enable bit n+NCH are both 1, or error bit n is 1.
- R8: Writing a 1 to bit n of the reset field through the overwrite, set or toggle alias starts a reset. `chan_rst[n]` is then high for exactly `RST_CYCLES` cycles, beginning the cycle after the write. Bit n reads 1 from that cycle for `RST_CYCLES+1` cycles and then reads 0. The clear alias of the reset field has no effect.
- R9: A write that hits a channel whose reset is already in progress neither restarts nor lengthens that reset. Zero bits in the write start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register and alias |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| cmplt_evt | input | NCH | Per-channel completion event pulse |
| err_evt | input | NCH | Per-channel error event pulse |
| err_is_bus | input | NCH | Error qualifier, valid with `err_evt`: 1 is bus error, 0 is termination |
| irq | output | NCH | Per-channel interrupt line |
| chan_rst | output | NCH | Per-channel reset pulse |

## Verification
Two things can reach the same flag bit in one clock: a hardware event setting it, and a software clear or overwrite acknowledging it. The bench provokes this by driving a completion pulse in the same cycle as a clear-alias write to that bit. It checks that the flag reads 1 afterwards and that its neighbours were cleared as written. The reset field has a similar race: a second start request arrives while a channel's pulse is in flight. The bench judges it by counting the pulse width of the busy channel, which must stay at `RST_CYCLES`, while a newly requested channel in the same write does start.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        GRP_RESET = 2'd0,
        GRP_DONE  = 2'd1,
        GRP_ERROR = 2'd2,
        GRP_NONE  = 2'd3
    } reg_grp_e;

    typedef enum logic [1:0] {
        CR_IDLE    = 2'd0,
        CR_PULSE   = 2'd1,
        CR_RELEASE = 2'd2
    } chrst_state_e;

endpackage

// File: rtl/dma_bank_decode.sv
module dma_bank_decode
    import dma_irq_pkg::*;
(
    input  logic [7:0] addr,
    input  logic       wr,
    output reg_grp_e   grp,
    output alias_op_e  op,
    output logic       wr_reset,
    output logic       wr_done,
    output logic       wr_error
);
    logic legal;

    always_comb begin
        legal = (addr[1:0] == 2'b00) && (addr[7:6] == 2'b00) && (addr[5:4] != 2'b11);
        op    = alias_op_e'(addr[3:2]);
        grp   = legal ? reg_grp_e'(addr[5:4]) : GRP_NONE;
    end

    always_comb begin
        wr_reset = wr && (grp == GRP_RESET);
        wr_done  = wr && (grp == GRP_DONE);
        wr_error = wr && (grp == GRP_ERROR);
    end

endmodule

// File: rtl/dma_alias_reg.sv
module dma_alias_reg
    import dma_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_mask,
    input  logic [W-1:0] hw_data,
    output logic [W-1:0] q
);
    logic [W-1:0] sw_next;
    logic [W-1:0] d;

    always_comb begin
        sw_next = q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE:  sw_next = wdata;
                OP_SET:    sw_next = q | wdata;
                OP_CLEAR:  sw_next = q & ~wdata;
                OP_TOGGLE: sw_next = q ^ wdata;
            endcase
        end
        d = (sw_next & ~hw_mask) | (hw_data & hw_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: a set access never drops a bit that no event touched
    a_r5_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET) |=>
            ((q & $past(q) & ~$past(hw_mask)) == ($past(q) & ~$past(hw_mask))));

    // R5: a clear access zeroes the written ones that no event touched
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLEAR) |=> ((q & $past(wdata & ~hw_mask)) == '0));

    // R6: an event's value always lands, whatever software did
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_mask) |=> (((q ^ $past(hw_data)) & $past(hw_mask)) == '0));

endmodule

// File: rtl/dma_chan_reset.sv
module dma_chan_reset
    import dma_irq_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic pulse
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    chrst_state_e state, state_d;
    logic [CW-1:0] cnt, cnt_d;

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            CR_IDLE: begin
                cnt_d = '0;
                if (start) state_d = CR_PULSE;
            end
            CR_PULSE: begin
                if (cnt == LAST) state_d = CR_RELEASE;
                else             cnt_d   = cnt + 1'b1;
            end
            CR_RELEASE: begin
                cnt_d   = '0;
                state_d = CR_IDLE;
            end
            default: state_d = CR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        pulse = (state == CR_PULSE);
        busy  = (state != CR_IDLE);
    end

    // independent run-length counter for the pulse-width check
    logic [31:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= '0;
        else if (pulse) run_len <= run_len + 1;
        else            run_len <= '0;
    end

    // R8: the pulse never runs longer than RST_CYCLES
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RST_CYCLES);

    // R8: a pulse only begins after a start request
    a_r8_pulse_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(start));

    // R9: a start seen while busy does not reopen the pulse
    a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pulse && start) |=> !pulse);

endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
    import dma_irq_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int DW         = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [7:0]     bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] cmplt_evt,
    input  logic [NCH-1:0] err_evt,
    input  logic [NCH-1:0] err_is_bus,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] chan_rst
);
    localparam int RW = 2 * NCH;

    reg_grp_e  grp;
    alias_op_e op;
    logic      wr_reset, wr_done, wr_error;

    dma_bank_decode u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .grp      (grp),
        .op       (op),
        .wr_reset (wr_reset),
        .wr_done  (wr_done),
        .wr_error (wr_error)
    );

    logic [RW-1:0] done_q, err_q;
    logic [RW-1:0] done_mask, done_data, err_mask, err_data;

    always_comb begin
        done_mask = {{NCH{1'b0}}, cmplt_evt};
        done_data = {RW{1'b1}};
        err_mask  = {err_evt, err_evt};
        err_data  = {err_is_bus, {NCH{1'b1}}};
    end

    dma_alias_reg #(.W(RW)) u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_done),
        .op      (op),
        .wdata   (bus_wdata[RW-1:0]),
        .hw_mask (done_mask),
        .hw_data (done_data),
        .q       (done_q)
    );

    dma_alias_reg #(.W(RW)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_error),
        .op      (op),
        .wdata   (bus_wdata[RW-1:0]),
        .hw_mask (err_mask),
        .hw_data (err_data),
        .q       (err_q)
    );

    logic [NCH-1:0] start, busy;

    always_comb begin
        start = '0;
        if (wr_reset && op != OP_CLEAR) start = bus_wdata[NCH-1:0];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dma_chan_reset #(.RST_CYCLES(RST_CYCLES)) u_rst (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start[n]),
            .busy  (busy[n]),
            .pulse (chan_rst[n])
        );
    end

    always_comb begin
        irq = (done_q[NCH-1:0] & done_q[RW-1:NCH]) | err_q[NCH-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (grp)
            GRP_RESET: bus_rdata[NCH-1:0] = busy;
            GRP_DONE:  bus_rdata[RW-1:0]  = done_q;
            GRP_ERROR: bus_rdata[RW-1:0]  = err_q;
            GRP_NONE:  bus_rdata          = '0;
        endcase
    end

    initial begin
        if (RW > DW) $error("dma_irq_bank: DW must hold two bits per channel");
    end

    // R7: an error event raises its interrupt on the next cycle
    a_r7_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_evt) |=> ((irq & $past(err_evt)) == $past(err_evt)));

    // R6: a completion event is never lost to a same-cycle write
    a_r6_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmplt_evt) |=> ((done_q[NCH-1:0] & $past(cmplt_evt)) == $past(cmplt_evt)));

    // R4: the error qualifier follows the event input
    a_r4_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_evt) |=> (((err_q[RW-1:NCH] ^ $past(err_is_bus)) & $past(err_evt)) == '0));

    // R8: the clear alias never starts a reset
    a_r8_clear_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reset && op == OP_CLEAR && busy == '0) |=> (chan_rst == '0));

endmodule

// File: tb/dma_irq_bank_tb.sv
module dma_irq_bank_tb;
    localparam int NCH = 16;
    localparam int DW  = 32;
    localparam int RC  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] cmplt_evt = '0, err_evt = '0, err_is_bus = '0;
    logic [NCH-1:0] irq, chan_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dma_irq_bank #(.NCH(NCH), .DW(DW), .RST_CYCLES(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmplt_evt(cmplt_evt),
        .err_evt(err_evt), .err_is_bus(err_is_bus), .irq(irq), .chan_rst(chan_rst)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // call at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 reset field", v, 32'h0);
        rd(8'h10, v); chk("R1 completion", v, 32'h0);
        rd(8'h20, v); chk("R1 error", v, 32'h0);
        chk("R1 irq", {16'h0, irq}, 32'h0);
        chk("R1 chan_rst", {16'h0, chan_rst}, 32'h0);
    endtask

    task automatic t_completion();
        logic [31:0] v, w;
        cmplt_evt = 16'h0004;
        @(negedge clk);
        cmplt_evt = '0;
        rd(8'h10, v); chk("R3 flag set", v, 32'h0000_0004);
        chk("R7 no irq without enable", {16'h0, irq}, 32'h0);
        wr(8'h14, 32'h0004_0000);
        chk("R7 irq with enable", {16'h0, irq}, 32'h0000_0004);
        wr(8'h14, 32'h0008_0000);
        rd(8'h10, v); chk("R5 set keeps others", v, 32'h000C_0004);
        rd(8'h14, w); chk("R2 alias reads same", w, v);
        wr(8'h1C, 32'h0008_0000);
        rd(8'h10, v); chk("R5 toggle", v, 32'h0004_0004);
        wr(8'h18, 32'h0000_0004);
        chk("R7 irq drops after clear", {16'h0, irq}, 32'h0);
        wr(8'h10, 32'h0000_0003);
        rd(8'h10, v); chk("R5 overwrite", v, 32'h0000_0003);
    endtask

    task automatic t_race();
        logic [31:0] v;
        cmplt_evt = 16'h0002;
        wr(8'h18, 32'h0000_0003);
        cmplt_evt = '0;
        rd(8'h10, v); chk("R6 event beats clear", v, 32'h0000_0002);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        err_evt = 16'h0010; err_is_bus = 16'h0010;
        @(negedge clk);
        err_evt = 16'h0200; err_is_bus = 16'h0000;
        @(negedge clk);
        err_evt = '0;
        rd(8'h20, v); chk("R4 bus error and termination", v, 32'h0010_0210);
        chk("R7 error irq", {16'h0, irq}, 32'h0000_0210);
        wr(8'h28, 32'h0010_0010);
        rd(8'h20, v); chk("R5 error clear", v, 32'h0000_0200);
        chk("R7 error irq after ack", {16'h0, irq}, 32'h0000_0200);
    endtask

    task automatic t_chan_reset();
        logic [31:0] v;
        int c;
        wr(8'h00, 32'h0000_0008);
        c = 0;
        rd(8'h00, v); chk("R8 busy reads 1", v, 32'h0000_0008);
        for (int i = 0; i < 20 && chan_rst[3]; i++) begin
            c++;
            @(negedge clk);
        end
        chk("R8 pulse width", c, RC);
        rd(8'h00, v); chk("R8 busy after pulse", v, 32'h0000_0008);
        @(negedge clk);
        rd(8'h00, v); chk("R8 busy cleared", v, 32'h0);
        wr(8'h08, 32'h0000_0004);
        chk("R8 clear alias inert", {16'h0, chan_rst}, 32'h0);
        rd(8'h00, v); chk("R8 clear alias no busy", v, 32'h0);
        wr(8'h0C, 32'h0000_0080);
        chk("R8 toggle starts", {16'h0, chan_rst}, 32'h0000_0080);
        repeat (RC + 2) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int c;
        wr(8'h04, 32'h0000_0020);
        c = chan_rst[5] ? 1 : 0;
        wr(8'h00, 32'h0000_0060);
        rd(8'h00, v); chk("R9 new channel starts", v, 32'h0000_0060);
        for (int i = 0; i < 20 && chan_rst[5]; i++) begin
            c++;
            @(negedge clk);
        end
        chk("R9 busy channel not extended", c, RC);
        repeat (RC + 2) @(negedge clk);
        rd(8'h00, v); chk("R9 all idle", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, v); chk("R2 unmapped reads 0", v, 32'h0);
        wr(8'h11, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R2 misaligned write ignored", v, 32'h0);
        chk("R2 no reset from bad address", {16'h0, chan_rst}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_completion();
        t_race();
        t_error();
        t_chan_reset();
        t_busy_ignore();
        t_unmapped();
        summary();
    end

endmodule